// File: doc/BRIEF.md
# Vector Paired Add-With-Carry Unit

This unit updates an accumulator vector one element pair at a time. The vector is split into pairs of elements, and every pair is processed in parallel. Each pair's even element is the accumulator. The addend is the odd element of the same pair in a first source vector. The carry-in is bit 0 of the odd element of the same pair in a second source vector. The sum goes back into the even element. The carry-out of that addition, zero-extended, replaces the odd element.

A one-bit size select chooses 32-bit or 64-bit elements. The vector length is a parameter and must be a multiple of 128 bits, so that whole pairs fill the vector at either size. A start strobe captures the operands. The updated vector appears on the next clock with a one-cycle done pulse, and it stays on the output until the next start.

Top module: `vec_pair_carry_add`

## Requirements
- R1: `size_sel_i` = 0 selects 32-bit elements and `size_sel_i` = 1 selects 64-bit elements. Element k occupies bits [k*W +: W], where W is the element width.
- R2: For each pair p, element 2p of the result equals (`acc_i` element 2p + `addend_i` element 2p+1 + carry-in) modulo 2^W.
- R3: The carry-in of pair p is bit 0 of `carry_src_i` element 2p+1. Every other bit of `carry_src_i` has no effect on the result.
- R4: Element 2p+1 of the result holds the unsigned carry-out of the pair's addition in bit 0, with all higher bits zero. The old odd element of `acc_i` has no effect.
- R5: Pairs are independent: an overflow in one pair does not change any other pair's result.
- R6: The even elements of `addend_i` have no effect on the result.
- R7: After a cycle with `start_i` high, `done_o` is high for exactly the following cycle and `result_o` shows the new vector. Without `start_i`, `result_o` holds its value.
- R8: A synchronous active-high `rst` clears `result_o` to zero and `done_o` to 0.
- R9: Starts in consecutive cycles each deliver their own result one cycle later, and `done_o` stays high across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Captures the operands and the size select |
| size_sel_i | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| acc_i | input | VLEN | Accumulator vector |
| addend_i | input | VLEN | First source vector (odd elements are the addends) |
| carry_src_i | input | VLEN | Second source vector (bit 0 of odd elements is the carry-in) |
| result_o | output | VLEN | Updated accumulator vector |
| done_o | output | 1 | One-cycle pulse when a new result is presented |

## Verification
A new capture and the presentation of the previous result can fall in the same cycle when `start_i` is held high on consecutive cycles. The bench drives two different operand sets back to back. In the cycle where the first result must appear, it checks that result while the second start is being accepted. In the following cycle it checks the second result with `done_o` still high, and one cycle after that it checks that `done_o` is low and the output has held. Within a single pair, a wrap of the sum and a carry written to the odd slot also happen in the same update. The bench provokes this with all-ones accumulators and a carry-in of 1, and it checks both halves of the pair against a bench-side model.

// File: rtl/vpac_pkg.sv
package vpac_pkg;

    typedef enum logic {
        ESZ_32 = 1'b0,
        ESZ_64 = 1'b1
    } esize_e;

    typedef struct packed {
        logic   done;
        esize_e sz;
    } vpac_ctl_t;

    function automatic int elem_width(input esize_e sz);
        return 32 << int'(sz);
    endfunction

    function automatic int pair_count(input int vlen, input esize_e sz);
        return vlen / (2 * elem_width(sz));
    endfunction

endpackage

// File: rtl/vpac_pair_add.sv
module vpac_pair_add #(
    parameter int EW = 32
) (
    input  logic [2*EW-1:0] acc_pair,
    input  logic [2*EW-1:0] add_pair,
    input  logic [2*EW-1:0] cin_pair,
    output logic [2*EW-1:0] res_pair
);
    logic [EW:0]   wide_sum;
    logic [EW-1:0] acc_even;
    logic          carry_in;
    logic          unused_bits;

    assign acc_even = acc_pair[EW-1:0];
    assign carry_in = cin_pair[EW];
    assign wide_sum = {1'b0, acc_even} + {1'b0, add_pair[2*EW-1:EW]} + {{EW{1'b0}}, carry_in};

    assign res_pair[EW-1:0]    = wide_sum[EW-1:0];
    assign res_pair[2*EW-1:EW] = {{(EW-1){1'b0}}, wide_sum[EW]};

    assign unused_bits = ^{acc_pair[2*EW-1:EW], add_pair[EW-1:0],
                           cin_pair[2*EW-1:EW+1], cin_pair[EW-1:0]};

    // A carry-out means the sum wrapped below the accumulator value;
    // without one, the sum cannot be below it.
    always_comb begin
        if (!$isunknown({acc_pair, add_pair, cin_pair})) begin
            p_wrap_r2: assert (res_pair[EW] ? (res_pair[EW-1:0] <= acc_even)
                                            : (res_pair[EW-1:0] >= acc_even));
        end
    end
endmodule

// File: rtl/vpac_lane_bank.sv
module vpac_lane_bank #(
    parameter int VLEN = 256,
    parameter int EW   = 32
) (
    input  logic [VLEN-1:0] acc_v,
    input  logic [VLEN-1:0] add_v,
    input  logic [VLEN-1:0] cin_v,
    output logic [VLEN-1:0] res_v
);
    localparam int PW    = 2 * EW;
    localparam int NPAIR = VLEN / PW;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        vpac_pair_add #(.EW(EW)) pair_i (
            .acc_pair (acc_v[p*PW +: PW]),
            .add_pair (add_v[p*PW +: PW]),
            .cin_pair (cin_v[p*PW +: PW]),
            .res_pair (res_v[p*PW +: PW])
        );
    end
endmodule

// File: rtl/vec_pair_carry_add.sv
module vec_pair_carry_add
    import vpac_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            size_sel_i,
    input  logic [VLEN-1:0] acc_i,
    input  logic [VLEN-1:0] addend_i,
    input  logic [VLEN-1:0] carry_src_i,
    output logic [VLEN-1:0] result_o,
    output logic            done_o
);
    localparam int NP32 = pair_count(VLEN, ESZ_32);
    localparam int NP64 = pair_count(VLEN, ESZ_64);

    esize_e          sz_req;
    logic [VLEN-1:0] res32, res64, res_next, res_q;
    vpac_ctl_t       ctl_q;

    assign sz_req = esize_e'(size_sel_i);

    vpac_lane_bank #(.VLEN(VLEN), .EW(32)) bank32_i (
        .acc_v (acc_i), .add_v (addend_i), .cin_v (carry_src_i), .res_v (res32)
    );

    vpac_lane_bank #(.VLEN(VLEN), .EW(64)) bank64_i (
        .acc_v (acc_i), .add_v (addend_i), .cin_v (carry_src_i), .res_v (res64)
    );

    assign res_next = (sz_req == ESZ_64) ? res64 : res32;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            ctl_q <= '{done: 1'b0, sz: ESZ_32};
        end else begin
            ctl_q.done <= start_i;
            if (start_i) begin
                res_q    <= res_next;
                ctl_q.sz <= sz_req;
            end
        end
    end

    assign result_o = res_q;
    assign done_o   = ctl_q.done;

    p_done_after_start_r7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    p_quiet_without_start_r7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(result_o));

    for (genvar g = 0; g < NP32; g++) begin : g_chk32
        p_odd_zero32_r4: assert property (@(posedge clk) disable iff (rst)
            (done_o && ctl_q.sz == ESZ_32) |-> (result_o[g*64+33 +: 31] == '0));
    end

    for (genvar g = 0; g < NP64; g++) begin : g_chk64
        p_odd_zero64_r4: assert property (@(posedge clk) disable iff (rst)
            (done_o && ctl_q.sz == ESZ_64) |-> (result_o[g*128+65 +: 63] == '0));
    end
endmodule

// File: tb/vec_pair_carry_add_tb_top.sv
module vec_pair_carry_add_tb_top;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          size_sel_i = 1'b0;
    logic [VL-1:0] acc_i = '0, addend_i = '0, carry_src_i = '0;
    logic [VL-1:0] result_o;
    logic          done_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    vec_pair_carry_add #(.VLEN(VL)) dut_i (
        .clk (clk), .rst (rst), .start_i (start_i), .size_sel_i (size_sel_i),
        .acc_i (acc_i), .addend_i (addend_i), .carry_src_i (carry_src_i),
        .result_o (result_o), .done_o (done_o)
    );

    function automatic logic [VL-1:0] model(input bit sz, input logic [VL-1:0] a,
                                            input logic [VL-1:0] s, input logic [VL-1:0] c);
        logic [VL-1:0] r = '0;
        if (sz) begin
            for (int p = 0; p < VL/128; p++) begin
                logic [64:0] t = {1'b0, a[p*128 +: 64]} + {1'b0, s[p*128+64 +: 64]}
                                 + {64'd0, c[p*128+64]};
                r[p*128 +: 64]    = t[63:0];
                r[p*128+64 +: 64] = {63'd0, t[64]};
            end
        end else begin
            for (int p = 0; p < VL/64; p++) begin
                logic [32:0] t = {1'b0, a[p*64 +: 32]} + {1'b0, s[p*64+32 +: 32]}
                                 + {32'd0, c[p*64+32]};
                r[p*64 +: 32]    = t[31:0];
                r[p*64+32 +: 32] = {31'd0, t[32]};
            end
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] pattern(input int seed);
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++)
            v[i*32 +: 32] = 32'h9E37_79B9 * (i + 1 + seed * 7) ^ (seed * 32'h0101_0101);
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s result act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s done act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic launch(input bit sz, input logic [VL-1:0] a,
                          input logic [VL-1:0] s, input logic [VL-1:0] c);
        @(negedge clk);
        start_i = 1'b1; size_sel_i = sz; acc_i = a; addend_i = s; carry_src_i = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_one(input string req, input bit sz, input logic [VL-1:0] a,
                           input logic [VL-1:0] s, input logic [VL-1:0] c);
        launch(sz, a, s, c);
        check_bit(req, done_o, 1'b1);
        check_vec(req, result_o, model(sz, a, s, c));
    endtask

    task automatic t_reset;
        check_vec("R8", result_o, '0);
        check_bit("R8", done_o, 1'b0);
    endtask

    task automatic t_size32;
        run_one("R1 R2", 1'b0, pattern(1), pattern(2), pattern(3));
        run_one("R2", 1'b0, pattern(4), pattern(5), '0);
    endtask

    task automatic t_size64;
        run_one("R1 R2", 1'b1, pattern(6), pattern(7), pattern(8));
        run_one("R2", 1'b1, pattern(9), pattern(10), {VL{1'b1}});
    endtask

    task automatic t_carry_bits;
        logic [VL-1:0] a = pattern(11), s = pattern(12), c = {VL{1'b1}};
        for (int k = 0; k < VL/64; k++) c[k*64+32] = 1'b0;
        launch(1'b0, a, s, c);
        check_vec("R3", result_o, model(1'b0, a, s, '0));
        check_vec("R4", result_o, model(1'b0, a & ~{(VL/64){32'hFFFF_FFFF, 32'h0}}, s, c));
        check_vec("R6", result_o, model(1'b0, a, s & ~{(VL/64){32'h0, 32'hFFFF_FFFF}}, c));
    endtask

    task automatic t_wrap;
        logic [VL-1:0] a = '0, s = '0, c = '0;
        a[63:0] = 64'hFFFF_FFFF_FFFF_FFFF;
        c[64] = 1'b1;
        a[191:128] = 64'd5;
        launch(1'b1, a, s, c);
        checks++;
        if (result_o[127:0] !== {64'd1, 64'd0}) begin
            failures++;
            $display("FAIL R4 pair0 act=%h exp=%h", result_o[127:0], {64'd1, 64'd0});
        end
        checks++;
        if (result_o[255:128] !== {64'd0, 64'd5}) begin
            failures++;
            $display("FAIL R5 pair1 act=%h exp=%h", result_o[255:128], {64'd0, 64'd5});
        end
        a = {(VL/32){32'hFFFF_FFFF}};
        c = {(VL/64){32'h1, 32'h0}};
        launch(1'b0, a, s, c);
        check_vec("R5 R4", result_o, {(VL/64){32'h1, 32'h0}});
    endtask

    task automatic t_hold;
        logic [VL-1:0] held;
        run_one("R7", 1'b0, pattern(13), pattern(14), pattern(15));
        held = result_o;
        acc_i = pattern(20); addend_i = pattern(21); size_sel_i = 1'b1;
        @(negedge clk);
        check_bit("R7", done_o, 1'b0);
        check_vec("R7", result_o, held);
        repeat (3) @(negedge clk);
        check_vec("R7", result_o, held);
    endtask

    task automatic t_back2back;
        logic [VL-1:0] e1 = model(1'b0, pattern(30), pattern(31), pattern(32));
        logic [VL-1:0] e2 = model(1'b1, pattern(33), pattern(34), pattern(35));
        @(negedge clk);
        start_i = 1'b1; size_sel_i = 1'b0;
        acc_i = pattern(30); addend_i = pattern(31); carry_src_i = pattern(32);
        @(negedge clk);
        check_bit("R9", done_o, 1'b1);
        check_vec("R9", result_o, e1);
        size_sel_i = 1'b1;
        acc_i = pattern(33); addend_i = pattern(34); carry_src_i = pattern(35);
        @(negedge clk);
        start_i = 1'b0;
        check_bit("R9", done_o, 1'b1);
        check_vec("R9", result_o, e2);
        @(negedge clk);
        check_bit("R9", done_o, 1'b0);
        check_vec("R9", result_o, e2);
    endtask

    task automatic t_reset_again;
        run_one("R8", 1'b1, pattern(40), pattern(41), pattern(42));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_size32();
        t_size64();
        t_carry_bits();
        t_wrap();
        t_hold();
        t_back2back();
        t_reset_again();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule